// File: doc/BRIEF.md
# Serial In-System Programming Command Framer

This block terminates a three-wire programming link (serial clock, data in, data out) on the system clock and turns the bit stream into complete flash transactions. Every command starts with an opcode byte followed by two address bytes. Short commands read a code byte, read a signature byte or write one code byte. Each of these is four bytes long. The long command loads a burst of data into an internal half-page buffer. The two address bytes are the high and low halves of a 16-bit address.

The block drives a simple flash port: an address, write data, a one-cycle write strobe per byte and a flag that selects the signature space. It takes back combinational read data. During the last byte of a read command it shifts the addressed byte out on the data-out line. Writes are carried out after the frame completes, one byte per system clock. A busy output covers that whole write period, and the block refuses serial input until it ends. The framer listens only while the target reset input is asserted. It also needs either the first reset period after power-up or a set enable fuse.

Top module: `isp_serial_framer`

## Requirements
- R1: Serial bits are taken most significant bit first on the rising edge of `sck`. `miso` changes only after a falling edge of `sck`, and it is 0 outside the data byte of a read command and after reset.
- R2: The byte read command uses opcode 0x20 in the frame [0x20][addr high][addr low][don't care]. During the fourth byte, `miso` returns the code byte at that address, with `fl_sig` low.
- R3: The signature read command uses opcode 0x28 in the same four-byte frame. It returns the signature-space byte at the address with `fl_sig` high. The three signature bytes sit at addresses 0x0000, 0x0001 and 0x0002.
- R4: The byte write command uses opcode 0x40 in the frame [0x40][addr high][addr low][data]. It produces exactly one `fl_we` cycle, carrying that address and data, and `busy` is high for exactly that one cycle.
- R5: The page command uses opcode 0x50 and is 67 bytes long: the opcode, two address bytes and then 64 data bytes. Data byte k (0..63) is written to the page base plus k, where the base is the address with its low 6 bits cleared. The writes happen in 64 consecutive `fl_we` cycles, and `busy` stays high for all of them.
- R6: No write strobe is issued for a page command until its 64th data byte has been received.
- R7: An opcode byte that is not 0x20, 0x28, 0x40 or 0x50 is dropped. The next byte is then taken as a new opcode.
- R8: A falling edge of `isp_rst` (reset release) discards any partially received frame.
- R9: Commands are accepted only while `isp_rst` is high. This holds only until the first release of `isp_rst` after `rst_n`, and afterwards only while `isp_fuse_en` is 1. When commands are not accepted, they cause no write and `miso` stays 0.
- R10: Serial clock edges that arrive while `busy` is high are ignored. They do not shift data and do not advance the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| isp_rst | input | 1 | Target reset, already resolved to active-high |
| isp_fuse_en | input | 1 | Programming-enable fuse |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| busy | output | 1 | Flash write in progress |
| fl_addr | output | 16 | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Write strobe, one byte per cycle |
| fl_sig | output | 1 | Selects the signature space for reads |
| fl_rdata | input | 8 | Read data from the flash stub |

## Verification
A byte counter that slips by one shifts every later frame by a byte. The next read then returns the wrong location, or the framer turns the opcode into an address, and this shows on `miso` within that same four-byte command. A wrong drain counter or page base shows as writes at the wrong addresses. Those writes appear only when the page is read back, but the count of `busy` and `fl_we` cycles exposes a wrong drain length on the cycle the burst ends. A blocking gate that leaks lets stray clock pulses during `busy` misalign the next read, so the fault shows on the first command after the write.

// File: rtl/isp_serial_framer.sv
module isp_serial_framer #(
  parameter int PAGE_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        isp_rst,
  input  logic        isp_fuse_en,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  output logic        busy,
  output logic [15:0] fl_addr,
  output logic [7:0]  fl_wdata,
  output logic        fl_we,
  output logic        fl_sig,
  input  logic [7:0]  fl_rdata
);
  localparam int CW = $clog2(PAGE_BYTES);
  localparam int LAST_IDX = PAGE_BYTES + 2;
  localparam int IW = $clog2(LAST_IDX + 1);
  localparam logic [7:0] OP_RD  = 8'h20;
  localparam logic [7:0] OP_SIG = 8'h28;
  localparam logic [7:0] OP_WR  = 8'h40;
  localparam logic [7:0] OP_PG  = 8'h50;
  localparam logic [15:0] PG_MASK = ~16'(PAGE_BYTES - 1);

  logic sck_q, sck_p, mosi_q, rst_q, rst_p, released;
  logic [2:0] bit_cnt;
  logic [IW-1:0] byte_idx;
  logic [6:0] sh;
  logic [7:0] op, a_hi, a_lo, out_sh;
  logic miso_r, busy_r;
  logic [7:0] buf_mem [PAGE_BYTES];
  logic [15:0] base;
  logic [CW-1:0] wcnt, wlast;

  wire rise = sck_q & ~sck_p;
  wire fall = ~sck_q & sck_p;
  wire rel  = rst_p & ~rst_q;
  wire accept = rst_q & (~released | isp_fuse_en) & ~busy_r;
  wire [7:0] rx = {sh, mosi_q};
  wire done = rise & accept & ~rel & (bit_cnt == 3'd7);
  wire known = (rx == OP_RD) || (rx == OP_SIG) || (rx == OP_WR) || (rx == OP_PG);
  wire rd_frame = ((op == OP_RD) || (op == OP_SIG)) && (byte_idx == IW'(3));
  wire [CW-1:0] off = CW'(byte_idx - IW'(3));

  assign miso     = miso_r;
  assign busy     = busy_r;
  assign fl_we    = busy_r;
  assign fl_addr  = busy_r ? base + 16'(wcnt) : {a_hi, a_lo};
  assign fl_wdata = buf_mem[wcnt];
  assign fl_sig   = ~busy_r & (op == OP_SIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; sck_p <= 1'b0; mosi_q <= 1'b0;
      rst_q <= 1'b0; rst_p <= 1'b0; released <= 1'b0;
    end else begin
      sck_q <= sck; sck_p <= sck_q; mosi_q <= mosi;
      rst_q <= isp_rst; rst_p <= rst_q;
      if (rel) released <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0; byte_idx <= '0; sh <= '0;
      op <= '0; a_hi <= '0; a_lo <= '0;
      busy_r <= 1'b0; base <= '0; wcnt <= '0; wlast <= '0;
    end else begin
      if (busy_r) begin
        if (wcnt == wlast) busy_r <= 1'b0;
        else wcnt <= wcnt + 1'b1;
      end
      if (!accept || rel) begin
        bit_cnt <= '0;
        byte_idx <= '0;
      end else if (rise) begin
        sh <= rx[6:0];
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          if (byte_idx == '0) begin
            op <= rx;
            byte_idx <= known ? IW'(1) : '0;
          end else if (byte_idx == IW'(1)) begin
            a_hi <= rx;
            byte_idx <= IW'(2);
          end else if (byte_idx == IW'(2)) begin
            a_lo <= rx;
            byte_idx <= IW'(3);
          end else if (op == OP_PG) begin
            if (byte_idx == IW'(LAST_IDX)) begin
              byte_idx <= '0;
              busy_r <= 1'b1;
              wcnt <= '0;
              wlast <= CW'(PAGE_BYTES - 1);
              base <= {a_hi, a_lo} & PG_MASK;
            end else begin
              byte_idx <= byte_idx + 1'b1;
            end
          end else begin
            byte_idx <= '0;
            if (op == OP_WR) begin
              busy_r <= 1'b1;
              wcnt <= '0;
              wlast <= '0;
              base <= {a_hi, a_lo};
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done && byte_idx >= IW'(3)) begin
      if (op == OP_PG) buf_mem[off] <= rx;
      else if (op == OP_WR) buf_mem[0] <= rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_r <= 1'b0;
      out_sh <= '0;
    end else if (fall) begin
      if (rd_frame && accept) begin
        if (bit_cnt == 3'd0) begin
          miso_r <= fl_rdata[7];
          out_sh <= {fl_rdata[6:0], 1'b0};
        end else begin
          miso_r <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end
      end else begin
        miso_r <= 1'b0;
      end
    end
  end

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso_r) |-> $past(fall)); // R1
  AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && $past(busy_r)) |-> (fl_addr == $past(fl_addr) + 16'd1)); // R5
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    byte_idx <= IW'(LAST_IDX)); // R5
  AST_WE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_r) |-> $past(done)); // R6
  AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r || !rst_q) |=> (bit_cnt == 3'd0 && byte_idx == '0)); // R10
  AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (released && !isp_fuse_en && !busy_r) |=> !fl_we); // R9
endmodule

// File: tb/isp_serial_framer_bench.sv
module isp_serial_framer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, isp_rst = 1'b1, isp_fuse_en = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, busy, fl_we, fl_sig;
  logic [15:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic [7:0] mem [8192];
  logic [7:0] exp_mem [8192];
  int n_chk = 0, n_fail = 0, we_cnt = 0, busy_cnt = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 13) + ((i >> 8) * 5) + 1);
  endfunction

  function automatic logic [7:0] sigv(input logic [15:0] a);
    return (a < 16'd3) ? 8'(8'h3C + a[7:0] * 8'h11) : 8'hFF;
  endfunction

  assign fl_rdata = fl_sig ? sigv(fl_addr) : mem[fl_addr[12:0]];

  always @(posedge clk) begin
    if (fl_we) begin
      mem[fl_addr[12:0]] <= fl_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (busy) busy_cnt <= busy_cnt + 1;
  end

  isp_serial_framer u_isp_serial_framer (
    .clk(clk), .rst_n(rst_n), .isp_rst(isp_rst), .isp_fuse_en(isp_fuse_en),
    .sck(sck), .mosi(mosi), .miso(miso), .busy(busy), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_sig(fl_sig), .fl_rdata(fl_rdata));

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r);
    for (int b = 7; b >= 0; b--) begin
      mosi = d[b];
      repeat (4) @(negedge clk);
      r[b] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd4(input logic [7:0] opc, input logic [15:0] a, input logic [7:0] d,
                      output logic [7:0] r);
    logic [7:0] x;
    xfer(opc, x); xfer(a[15:8], x); xfer(a[7:0], x); xfer(d, r);
  endtask

  initial begin
    logic [7:0] r, x;
    int w0, b0;
    for (int i = 0; i < 8192; i++) begin
      mem[i] = init_val(i);
      exp_mem[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset miso", int'(miso), 0);
    chk("R4 reset busy", int'(busy), 0);
    chk("R4 reset fl_we", int'(fl_we), 0);

    // R2 sweep of code reads, also checks R1 bit order
    for (int k = 0; k < 32; k++) begin
      logic [15:0] a = 16'((k * 259 + k) & 16'h1FFF);
      cmd4(8'h20, a, 8'h00, r);
      chk("R2 byte read", int'(r), int'(exp_mem[a[12:0]]));
    end

    // R3 signature bytes
    for (int k = 0; k < 3; k++) begin
      cmd4(8'h28, 16'(k), 8'h00, r);
      chk("R3 signature", int'(r), int'(sigv(16'(k))));
    end

    // R4 byte write
    w0 = we_cnt; b0 = busy_cnt;
    cmd4(8'h40, 16'h0123, 8'h5A, x);
    exp_mem[16'h0123] = 8'h5A;
    wait_idle();
    chk("R4 strobe count", we_cnt - w0, 1);
    chk("R4 busy cycles", busy_cnt - b0, 1);
    cmd4(8'h20, 16'h0123, 8'h00, r);
    chk("R4 readback", int'(r), 8'h5A);
    cmd4(8'h20, 16'h0124, 8'h00, r);
    chk("R4 neighbour", int'(r), int'(exp_mem[16'h0124]));

    // R5 / R6 page load and write, base 0x0440
    w0 = we_cnt; b0 = busy_cnt;
    xfer(8'h50, x); xfer(8'h04, x); xfer(8'h57, x);
    for (int k = 0; k < 64; k++) begin
      logic [7:0] d = 8'(k * 7 + 3);
      if (k == 63) begin
        repeat (4) @(negedge clk);
        chk("R6 no strobe before last byte", we_cnt - w0, 0);
      end
      xfer(d, x);
      exp_mem[13'h0440 + 13'(k)] = d;
    end
    wait_idle();
    chk("R5 strobe count", we_cnt - w0, 64);
    chk("R5 busy cycles", busy_cnt - b0, 64);
    for (int k = 0; k < 64; k++) begin
      cmd4(8'h20, 16'h0440 + 16'(k), 8'h00, r);
      chk("R5 page readback", int'(r), int'(exp_mem[13'h0440 + 13'(k)]));
    end
    cmd4(8'h20, 16'h043F, 8'h00, r);
    chk("R5 below page", int'(r), int'(exp_mem[13'h043F]));
    cmd4(8'h20, 16'h0480, 8'h00, r);
    chk("R5 above page", int'(r), int'(exp_mem[13'h0480]));

    // R10 pulses during busy are ignored
    xfer(8'h50, x); xfer(8'h08, x); xfer(8'h80, x);
    for (int k = 0; k < 64; k++) begin
      logic [7:0] d = 8'(255 - k * 3);
      xfer(d, x);
      exp_mem[13'h0880 + 13'(k)] = d;
    end
    chk("R10 busy during write", int'(busy), 1);
    for (int p = 0; p < 4; p++) begin
      mosi = 1'b1;
      @(negedge clk); sck = 1'b1;
      @(negedge clk); sck = 1'b0;
    end
    wait_idle();
    cmd4(8'h20, 16'h0885, 8'h00, r);
    chk("R10 aligned after busy", int'(r), int'(exp_mem[13'h0885]));

    // R7 unknown opcodes dropped
    xfer(8'h77, x);
    xfer(8'hFF, x);
    cmd4(8'h20, 16'h0100, 8'h00, r);
    chk("R7 read after bad opcode", int'(r), int'(exp_mem[13'h0100]));

    // R9 locked after release with fuse clear
    isp_rst = 1'b0; repeat (6) @(negedge clk);
    isp_rst = 1'b1; repeat (6) @(negedge clk);
    w0 = we_cnt;
    cmd4(8'h40, 16'h0005, 8'hEE, x);
    wait_idle();
    chk("R9 locked no write", we_cnt - w0, 0);
    cmd4(8'h20, 16'h0005, 8'h00, r);
    chk("R9 locked miso quiet", int'(r), 0);
    isp_fuse_en = 1'b1;
    repeat (4) @(negedge clk);
    cmd4(8'h20, 16'h0005, 8'h00, r);
    chk("R9 fuse enables", int'(r), int'(exp_mem[13'h0005]));

    // R8 release discards a partial frame
    w0 = we_cnt;
    xfer(8'h40, x); xfer(8'h00, x);
    isp_rst = 1'b0; repeat (6) @(negedge clk);
    isp_rst = 1'b1; repeat (6) @(negedge clk);
    cmd4(8'h20, 16'h0200, 8'h00, r);
    wait_idle();
    chk("R8 read after abort", int'(r), int'(exp_mem[13'h0200]));
    chk("R8 no stray write", we_cnt - w0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule